// File: doc/BRIEF.md
# Doorbell-Driven Packet Fetch Engine

This block moves command packets from a ring in host memory into a smaller local packet ring. Software announces new work by writing the host ring's write index to a doorbell. The block works out how many packets are waiting from the host read and write indices and claims free slots in the local ring. It then issues DMA read requests that copy the packets across. When every request of a series has completed, it pulses a wakeup for the dispatcher that consumes the local ring.

Both rings have power-of-two sizes. A copy is cut into chunks so that no single DMA request runs past the end of either ring. The local ring can hold fewer packets than are waiting. When that happens the engine fetches what fits, raises a stall flag, and resumes by itself when the consumer hands slots back. A doorbell that arrives while a series is in flight does not start anything at once. It is remembered and examined when the series completes.

Top module: `pkt_fetch_engine`

## Requirements
- R1: A doorbell with `db_bytes` = 8 sets the host write index to the low `IDX_W` bits of `db_data` plus one. A doorbell with `db_bytes` = 4 sets it to `db_data[31:0]` unchanged. The new index shows on `host_wr_idx` after the accepting edge.
- R2: A doorbell of any other size raises `db_err` for exactly one cycle and leaves the host write index unchanged.
- R3: If the host write index equals the host read index when the engine checks for work, no DMA request is issued and `busy` stays low.
- R4: A series claims grant = min(waiting packets, free local slots). `host_rd_idx` advances by the grant, and the free-slot count drops by the grant. The free count starts at `LOCAL_DEPTH` and rises by `rel_count` on each `rel_valid` cycle.
- R5: Each request's length is the minimum of four values: host entries left before the host ring wraps, local entries left before the local ring wraps, packets still to fetch, and claimed slots still unused. `dma_req_addr` = `host_base` + host position × `PKT_BYTES`. `dma_req_lidx` is the local ring position. Both positions advance modulo their own ring sizes.
- R6: `stalled` is set when the grant is smaller than the number of waiting packets, including a grant of zero. While stalled, a rise of the free count above zero restarts fetching without a doorbell.
- R7: A doorbell accepted while `busy` is high issues no request before the series completes. The engine checks the host indices again right after completion.
- R8: Each `dma_ack_valid` subtracts the length of the request carrying `dma_ack_tag` from the outstanding count. When that count reaches zero, `busy` falls and `wakeup` pulses high for one cycle.
- R9: Request tags count up by one per request, modulo 2^`TAG_W`, across series. A request holds its fields steady until `dma_req_ready`.
- R10: After reset, `busy`, `stalled`, `wakeup`, `db_err` and `dma_req_valid` are low, and both host indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_bytes | input | 4 | Doorbell write size in bytes (4 or 8 are legal) |
| db_data | input | 64 | Doorbell write data |
| host_base | input | ADDR_W | Byte address of host ring entry 0 |
| rel_valid | input | 1 | Local slots handed back by the consumer |
| rel_count | input | clog2(LOCAL_DEPTH+1) | Number of slots handed back |
| dma_req_valid | output | 1 | DMA read request present |
| dma_req_ready | input | 1 | DMA port accepts the request |
| dma_req_addr | output | ADDR_W | Host byte address of the chunk |
| dma_req_len | output | clog2(LOCAL_DEPTH+1) | Chunk length in packets |
| dma_req_lidx | output | clog2(LOCAL_DEPTH) | Local ring slot of the first packet |
| dma_req_tag | output | TAG_W | Request tag |
| dma_ack_valid | input | 1 | In-order completion strobe |
| dma_ack_tag | input | TAG_W | Tag of the completed request |
| wakeup | output | 1 | One-cycle pulse when a series completes |
| busy | output | 1 | A series is in flight |
| stalled | output | 1 | Fetch is waiting for local slots |
| db_err | output | 1 | One-cycle pulse on an illegal doorbell size |
| host_rd_idx | output | IDX_W | Host ring read index |
| host_wr_idx | output | IDX_W | Host ring write index |

## Verification
The hardest case to reach is a series that splits into three chunks. That needs a host-ring wrap and a local-ring wrap inside the same grant, which only happens once many earlier series have moved both positions to unaligned places. The bench sweeps a small configuration (an 8-entry host ring and a 4-entry local ring) through a long sequence of doorbells of varying sizes and partial slot releases. A running arithmetic model of both positions predicts every chunk, stall and resume. A directed step also rings during a live series to show the deferred recheck.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2
  } fetch_state_e;

  localparam logic [3:0] DB_NARROW = 4'd4;
  localparam logic [3:0] DB_WIDE   = 4'd8;
endpackage

// File: rtl/fetch_slot_pool.sv
`timescale 1ns/1ps
module fetch_slot_pool #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_en,
  input  logic [$clog2(DEPTH+1)-1:0]   alloc_n,
  input  logic                         rel_en,
  input  logic [$clog2(DEPTH+1)-1:0]   rel_n,
  output logic [$clog2(DEPTH+1)-1:0]   free_cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] free_q;

  always_ff @(posedge clk) begin
    if (rst) free_q <= CNT_W'(DEPTH);
    else     free_q <= free_q - (alloc_en ? alloc_n : '0) + (rel_en ? rel_n : '0);
  end

  assign free_cnt = free_q;

  // R4
  free_cap_chk: assert property (@(posedge clk) disable iff (rst)
    free_q <= CNT_W'(DEPTH));
  // R4
  alloc_fit_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (alloc_n <= free_q && alloc_n != '0));
endmodule

// File: rtl/fetch_chunk_sizer.sv
`timescale 1ns/1ps
module fetch_chunk_sizer #(
  parameter int HOST_DEPTH  = 64,
  parameter int LOCAL_DEPTH = 16,
  parameter int IDX_W       = 32
) (
  input  logic [$clog2(HOST_DEPTH)-1:0]    hpos,
  input  logic [$clog2(LOCAL_DEPTH)-1:0]   lpos,
  input  logic [IDX_W-1:0]                 left_host,
  input  logic [IDX_W-1:0]                 left_grant,
  output logic [$clog2(LOCAL_DEPTH+1)-1:0] chunk_len
);
  localparam int LCNT_W = $clog2(LOCAL_DEPTH + 1);

  logic [IDX_W-1:0] h_room, l_room, m_rooms, m_left, m_all;

  always_comb begin
    h_room  = IDX_W'(HOST_DEPTH) - IDX_W'(hpos);
    l_room  = IDX_W'(LOCAL_DEPTH) - IDX_W'(lpos);
    m_rooms = (h_room < l_room) ? h_room : l_room;
    m_left  = (left_host < left_grant) ? left_host : left_grant;
    m_all   = (m_rooms < m_left) ? m_rooms : m_left;
  end

  assign chunk_len = LCNT_W'(m_all);
endmodule

// File: rtl/fetch_len_store.sv
`timescale 1ns/1ps
module fetch_len_store #(
  parameter int TAG_W = 2,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [TAG_W-1:0] waddr,
  input  logic [LEN_W-1:0] wdata,
  input  logic [TAG_W-1:0] raddr,
  output logic [LEN_W-1:0] rdata
);
  logic [LEN_W-1:0] mem [2**TAG_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_fetch_engine.sv
`timescale 1ns/1ps
module pkt_fetch_engine
  import fetch_pkg::*;
#(
  parameter int HOST_DEPTH  = 64,
  parameter int LOCAL_DEPTH = 16,
  parameter int IDX_W       = 32,
  parameter int ADDR_W      = 48,
  parameter int PKT_BYTES   = 64,
  parameter int TAG_W       = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               db_valid,
  input  logic [3:0]                         db_bytes,
  input  logic [63:0]                        db_data,
  input  logic [ADDR_W-1:0]                  host_base,
  input  logic                               rel_valid,
  input  logic [$clog2(LOCAL_DEPTH+1)-1:0]   rel_count,
  output logic                               dma_req_valid,
  input  logic                               dma_req_ready,
  output logic [ADDR_W-1:0]                  dma_req_addr,
  output logic [$clog2(LOCAL_DEPTH+1)-1:0]   dma_req_len,
  output logic [$clog2(LOCAL_DEPTH)-1:0]     dma_req_lidx,
  output logic [TAG_W-1:0]                   dma_req_tag,
  input  logic                               dma_ack_valid,
  input  logic [TAG_W-1:0]                   dma_ack_tag,
  output logic                               wakeup,
  output logic                               busy,
  output logic                               stalled,
  output logic                               db_err,
  output logic [IDX_W-1:0]                   host_rd_idx,
  output logic [IDX_W-1:0]                   host_wr_idx
);
  localparam int HPOS_W    = $clog2(HOST_DEPTH);
  localparam int LPOS_W    = $clog2(LOCAL_DEPTH);
  localparam int LCNT_W    = $clog2(LOCAL_DEPTH + 1);
  localparam int PKT_SHIFT = $clog2(PKT_BYTES);

  fetch_state_e       state_q;
  logic [IDX_W-1:0]   wr_q, rd_q, left_host_q, left_grant_q, remain_q;
  logic [HPOS_W-1:0]  hpos_q;
  logic [LPOS_W-1:0]  lpos_q;
  logic [TAG_W-1:0]   tag_q;
  logic               pend_q, stalled_q, busy_q, wake_q, err_q;
  logic               req_v_q;
  logic [ADDR_W-1:0]  req_addr_q;
  logic [LCNT_W-1:0]  req_len_q;
  logic [LPOS_W-1:0]  req_lidx_q;
  logic [TAG_W-1:0]   req_tag_q;

  logic [LCNT_W-1:0]  free_cnt, chunk_len, ack_len;
  logic [IDX_W-1:0]   waiting, grant, remain_nx;
  logic               start_chk, series_go, chunk_load;

  assign waiting    = wr_q - rd_q;
  assign grant      = (waiting < IDX_W'(free_cnt)) ? waiting : IDX_W'(free_cnt);
  assign start_chk  = (state_q == FS_IDLE) && (pend_q || (stalled_q && free_cnt != '0));
  assign series_go  = start_chk && waiting != '0 && grant != '0;
  assign chunk_load = (state_q == FS_ISSUE) && !req_v_q;
  assign remain_nx  = remain_q - IDX_W'(ack_len);

  fetch_slot_pool #(.DEPTH(LOCAL_DEPTH)) u_pool (
    .clk(clk), .rst(rst),
    .alloc_en(series_go), .alloc_n(LCNT_W'(grant)),
    .rel_en(rel_valid), .rel_n(rel_count),
    .free_cnt(free_cnt)
  );

  fetch_chunk_sizer #(.HOST_DEPTH(HOST_DEPTH), .LOCAL_DEPTH(LOCAL_DEPTH), .IDX_W(IDX_W)) u_sizer (
    .hpos(hpos_q), .lpos(lpos_q),
    .left_host(left_host_q), .left_grant(left_grant_q),
    .chunk_len(chunk_len)
  );

  fetch_len_store #(.TAG_W(TAG_W), .LEN_W(LCNT_W)) u_lens (
    .clk(clk), .we(chunk_load), .waddr(tag_q), .wdata(chunk_len),
    .raddr(dma_ack_tag), .rdata(ack_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      wr_q <= '0; rd_q <= '0; left_host_q <= '0; left_grant_q <= '0; remain_q <= '0;
      hpos_q <= '0; lpos_q <= '0; tag_q <= '0;
      pend_q <= 1'b0; stalled_q <= 1'b0; busy_q <= 1'b0; wake_q <= 1'b0; err_q <= 1'b0;
      req_v_q <= 1'b0; req_addr_q <= '0; req_len_q <= '0; req_lidx_q <= '0; req_tag_q <= '0;
    end else begin
      wake_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        FS_IDLE: if (start_chk) begin
          pend_q <= 1'b0;
          if (waiting != '0) begin
            if (grant == '0) begin
              stalled_q <= 1'b1;
            end else begin
              rd_q         <= rd_q + grant;
              hpos_q       <= rd_q[HPOS_W-1:0];
              left_host_q  <= waiting;
              left_grant_q <= grant;
              remain_q     <= grant;
              stalled_q    <= (grant < waiting);
              busy_q       <= 1'b1;
              state_q      <= FS_ISSUE;
            end
          end
        end
        FS_ISSUE: if (!req_v_q) begin
          req_v_q      <= 1'b1;
          req_addr_q   <= host_base + (ADDR_W'(hpos_q) << PKT_SHIFT);
          req_len_q    <= chunk_len;
          req_lidx_q   <= lpos_q;
          req_tag_q    <= tag_q;
          tag_q        <= tag_q + 1'b1;
          hpos_q       <= hpos_q + HPOS_W'(chunk_len);
          lpos_q       <= lpos_q + LPOS_W'(chunk_len);
          left_host_q  <= left_host_q - IDX_W'(chunk_len);
          left_grant_q <= left_grant_q - IDX_W'(chunk_len);
        end else if (dma_req_ready) begin
          req_v_q <= 1'b0;
          if (left_grant_q == '0) state_q <= FS_WAIT;
        end
        default: ;
      endcase
      if (dma_ack_valid) begin
        remain_q <= remain_nx;
        if (remain_nx == '0) begin
          busy_q  <= 1'b0;
          wake_q  <= 1'b1;
          pend_q  <= 1'b1;
          state_q <= FS_IDLE;
        end
      end
      if (db_valid) begin
        case (db_bytes)
          DB_WIDE:   begin wr_q <= db_data[IDX_W-1:0] + 1'b1;  pend_q <= 1'b1; end
          DB_NARROW: begin wr_q <= IDX_W'(db_data[31:0]);      pend_q <= 1'b1; end
          default:   err_q <= 1'b1;
        endcase
      end
    end
  end

  assign dma_req_valid = req_v_q;
  assign dma_req_addr  = req_addr_q;
  assign dma_req_len   = req_len_q;
  assign dma_req_lidx  = req_lidx_q;
  assign dma_req_tag   = req_tag_q;
  assign wakeup        = wake_q;
  assign busy          = busy_q;
  assign stalled       = stalled_q;
  assign db_err        = err_q;
  assign host_rd_idx   = rd_q;
  assign host_wr_idx   = wr_q;

  // R5
  chunk_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> dma_req_len != '0);
  // R5
  local_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> (32'(dma_req_lidx) + 32'(dma_req_len)) <= 32'(LOCAL_DEPTH));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && !dma_req_ready) |=> (dma_req_valid && $stable(dma_req_addr)
      && $stable(dma_req_len) && $stable(dma_req_tag)));
  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wakeup |-> !busy);
  // R7
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> busy);
endmodule

// File: tb/tb_pkt_fetch_engine.sv
`timescale 1ns/1ps
module tb_pkt_fetch_engine;
  localparam int H = 8;
  localparam int L = 4;
  localparam int PB = 64;
  localparam int TW = 2;
  localparam longint BASE = 64'h1000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic db_valid = 1'b0;
  logic [3:0] db_bytes = '0;
  logic [63:0] db_data = '0;
  logic [31:0] host_base = BASE[31:0];
  logic rel_valid = 1'b0;
  logic [2:0] rel_count = '0;
  logic dma_req_valid, dma_req_ready;
  logic [31:0] dma_req_addr;
  logic [2:0] dma_req_len;
  logic [1:0] dma_req_lidx, dma_req_tag;
  logic dma_ack_valid = 1'b0;
  logic [1:0] dma_ack_tag = '0;
  logic wakeup, busy, stalled, db_err;
  logic [31:0] host_rd_idx, host_wr_idx;

  assign dma_req_ready = 1'b1;

  pkt_fetch_engine #(.HOST_DEPTH(H), .LOCAL_DEPTH(L), .IDX_W(32), .ADDR_W(32),
                     .PKT_BYTES(PB), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .db_valid(db_valid), .db_bytes(db_bytes), .db_data(db_data),
    .host_base(host_base), .rel_valid(rel_valid), .rel_count(rel_count),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr),
    .dma_req_len(dma_req_len), .dma_req_lidx(dma_req_lidx), .dma_req_tag(dma_req_tag),
    .dma_ack_valid(dma_ack_valid), .dma_ack_tag(dma_ack_tag), .wakeup(wakeup), .busy(busy),
    .stalled(stalled), .db_err(db_err), .host_rd_idx(host_rd_idx), .host_wr_idx(host_wr_idx)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_wr = 0, m_rd = 0, m_free = L, m_lpos = 0, m_tag = 0;
  bit m_stall = 0;
  longint eaddr[8];
  int elen[8], elidx[8], etag[8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doorbell(input logic [3:0] sz, input logic [63:0] val);
    @(negedge clk);
    db_valid = 1'b1; db_bytes = sz; db_data = val;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic ring(input int n, input bit wide);
    m_wr += n;
    if (wide) doorbell(4'd8, {32'hA5A5_0000, 32'(m_wr - 1)});
    else      doorbell(4'd4, {32'h5A5A_FFFF, 32'(m_wr)});
    chk(host_wr_idx == 32'(m_wr), wide ? "R1 wide doorbell" : "R1 narrow doorbell",
        host_wr_idx, m_wr);
  endtask

  task automatic run_series(input int extra);
    int waiting, grant, left, hp, lp, n, i, c;
    waiting = m_wr - m_rd;
    grant = (waiting < m_free) ? waiting : m_free;
    n = 0; left = grant; hp = m_rd % H; lp = m_lpos;
    while (left > 0) begin
      c = H - hp;
      if (L - lp < c) c = L - lp;
      if (left < c) c = left;
      eaddr[n] = BASE + hp * PB; elen[n] = c; elidx[n] = lp; etag[n] = (m_tag + n) % 4;
      hp = (hp + c) % H; lp = (lp + c) % L; left -= c; n++;
    end
    i = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (dma_req_valid) begin
        if (i < n) begin
          chk(dma_req_addr == 32'(eaddr[i]), "R5 chunk address", dma_req_addr, eaddr[i]);
          chk(dma_req_len == 3'(elen[i]), "R5 chunk length", dma_req_len, elen[i]);
          chk(dma_req_lidx == 2'(elidx[i]), "R5 local index", dma_req_lidx, elidx[i]);
          chk(dma_req_tag == 2'(etag[i]), "R9 tag", dma_req_tag, etag[i]);
        end else chk(1'b0, "R3 unexpected request", i, n);
        i++;
      end
    end
    chk(i == n, "R5 request count", i, n);
    m_rd += grant; m_free -= grant; m_lpos = (m_lpos + grant) % L; m_tag = (m_tag + n) % 4;
    if (waiting > 0) m_stall = (grant < waiting);
    chk(host_rd_idx == 32'(m_rd), "R4 read index", host_rd_idx, m_rd);
    chk(stalled == m_stall, "R6 stall flag", stalled, m_stall);
    if (n > 0) begin
      chk(busy == 1'b1, "R8 busy in series", busy, 1);
      if (extra > 0) begin
        ring(extra, 1'b0);
        for (int cyc = 0; cyc < 6; cyc++) begin
          @(negedge clk);
          chk(!dma_req_valid, "R7 doorbell while busy", dma_req_valid, 0);
        end
      end
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (k > 0) chk(!wakeup, "R8 early wakeup", wakeup, 0);
        dma_ack_valid = 1'b1; dma_ack_tag = 2'(etag[k]);
      end
      @(negedge clk);
      dma_ack_valid = 1'b0;
      chk(wakeup == 1'b1, "R8 wakeup", wakeup, 1);
      chk(busy == 1'b0, "R8 busy clear", busy, 0);
      @(negedge clk);
      chk(wakeup == 1'b0, "R8 wakeup one cycle", wakeup, 0);
    end else begin
      chk(busy == 1'b0, "R3 idle without grant", busy, 0);
    end
  endtask

  task automatic release_slots(input int r);
    @(negedge clk);
    rel_valid = 1'b1; rel_count = 3'(r);
    @(negedge clk);
    rel_valid = 1'b0;
    m_free += r;
    if (m_stall) run_series(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cap, n, r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(!busy && !stalled && !wakeup && !db_err && !dma_req_valid, "R10 reset outputs", busy, 0);
    chk(host_rd_idx == 0 && host_wr_idx == 0, "R10 reset indices", host_rd_idx, 0);
    // R3: doorbell restating the same write index
    ring(0, 1'b0);
    run_series(0);
    // R2: illegal size
    @(negedge clk);
    db_valid = 1'b1; db_bytes = 4'd2; db_data = 64'd5;
    @(negedge clk);
    db_valid = 1'b0;
    chk(db_err == 1'b1, "R2 error pulse", db_err, 1);
    chk(host_wr_idx == 32'(m_wr), "R2 index kept", host_wr_idx, m_wr);
    @(negedge clk);
    chk(db_err == 1'b0, "R2 error one cycle", db_err, 0);
    chk(!dma_req_valid, "R2 no request", dma_req_valid, 0);
    // R7: doorbell during a series, then recheck on completion
    ring(3, 1'b1);
    run_series(2);
    run_series(0);
    release_slots(3);
    // sweep
    for (int it = 0; it < 30; it++) begin
      cap = H - (m_wr - m_rd);
      n = 1 + (it * 5) % 7;
      if (n > cap) n = cap;
      if (n > 0) begin
        ring(n, it[0]);
        run_series(0);
      end
      r = 1 + it % 3;
      if (r > L - m_free) r = L - m_free;
      if (r > 0) release_slots(r);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule